// File: doc/BRIEF.md
# Timer Interrupt Flag and Prescaler-Reset Control

This block holds the status and control state for one 8-bit timer/counter. It keeps two sticky event flags, one for counter overflow and one for compare match. Each flag is gated with its own enable and with a global interrupt enable to produce an interrupt request line. Software clears a flag by writing a one to its bit. The interrupt controller clears it by acknowledging the matching vector. When the timer runs in phase-correct PWM mode, the overflow flag follows the counter's turn-around at zero instead of its wrap.

A second register holds a synchronization-mode bit and a prescaler-reset bit. Setting the reset bit drives the prescaler-reset output. In synchronous operation the bit drops again one cycle later. In asynchronous operation it stays up until the prescaler reports that its reset is done. While the synchronization-mode bit is set, hardware never drops it, so software can hold the prescaler stopped and release it later. The counter, the comparator and the prescaler are outside this block. It sees only their event pulses and the done handshake.

Top module: `tmr_flag_ctrl`

## Requirements
- R1: After reset every readable bit is 0. The flag register (reg_sel=0) shows the compare flag on bit 1 and the overflow flag on bit 0. The control register (reg_sel=1) shows the sync-mode bit on bit 7 and the prescaler-reset bit on bit 1. Every other bit of both registers reads 0, whatever was written to it.
- R2: A cnt_match pulse sets the compare flag at the next clock edge. With pwm_mode=0, a cnt_ovf pulse sets the overflow flag at the next clock edge.
- R3: With pwm_mode=1, cnt_bottom sets the overflow flag and cnt_ovf has no effect on it.
- R4: Writing the flag register with a 1 in a flag's bit clears that flag. A 0 in that bit leaves the flag unchanged.
- R5: ack_ovf clears the overflow flag and ack_cmp clears the compare flag at the next edge.
- R6: When a set event and a clear (write-one or acknowledge) reach the same flag in the same cycle, the flag ends up 1.
- R7: irq_ovf is 1 exactly while gie, ovf_ie and the overflow flag are all 1. irq_cmp is 1 exactly while gie, cmp_ie and the compare flag are all 1.
- R8: A control-register write loads the sync-mode bit from wdata bit 7. A 1 in wdata bit 1 sets the prescaler-reset bit. A 0 there does not clear it. psr_out always equals the prescaler-reset bit.
- R9: With sync-mode 0 and async_mode 0, the prescaler-reset bit is 1 for exactly one cycle after it is written.
- R10: With sync-mode 0 and async_mode 1, the prescaler-reset bit stays 1 until a cycle with psr_done=1, and it reads 0 after that edge.
- R11: While sync-mode is 1, the prescaler-reset bit stays 1 regardless of async_mode or psr_done.
- R12: If sync-mode is cleared while the prescaler-reset bit is 1, the bit is kept for the cycle of that write. After that, the rule of R9 or R10 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | 0 selects the flag register, 1 the control register |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| cnt_ovf | input | 1 | Counter wrapped (normal modes) |
| cnt_bottom | input | 1 | Counter reversed direction at zero (PWM mode) |
| cnt_match | input | 1 | Counter equals compare value |
| pwm_mode | input | 1 | Phase-correct PWM mode active |
| gie | input | 1 | Global interrupt enable |
| ovf_ie | input | 1 | Overflow interrupt enable |
| cmp_ie | input | 1 | Compare interrupt enable |
| ack_ovf | input | 1 | Overflow vector acknowledge |
| ack_cmp | input | 1 | Compare vector acknowledge |
| async_mode | input | 1 | Prescaler runs asynchronously |
| psr_done | input | 1 | Prescaler reports its reset complete |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_cmp | output | 1 | Compare interrupt request |
| psr_out | output | 1 | Prescaler reset command |

## Verification
Two functions can meet on one flag in a single cycle: a hardware set event and a clear, where the clear comes either from a one-written bit or from a vector acknowledge. The bench lines up set pulses with both kinds of clear in the same cycle and expects the flag to stay 1. A second meeting happens on the prescaler-reset bit, where a new write of 1 can arrive in the same cycle as psr_done. The write must win. Directed cases and a long pseudo-random stretch provoke both meetings. A behavioural model of the register state judges every cycle.

// File: rtl/tfc_pkg.sv
package tfc_pkg;
  localparam int unsigned TFC_DW    = 8;
  localparam int unsigned TFC_NFLAG = 2;
  // flag register layout: index equals the flag instance number
  localparam int unsigned OVF_BIT   = 0;
  localparam int unsigned CMP_BIT   = 1;
  // control register layout
  localparam int unsigned PSR_BIT   = 1;
  localparam int unsigned TSM_BIT   = 7;

  typedef enum logic {
    SEL_FLAGS = 1'b0,
    SEL_CTRL  = 1'b1
  } tfc_sel_e;
endpackage

// File: rtl/tfc_rst_sync.sv
module tfc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_q = chain_q[STAGES-1];
endmodule

// File: rtl/tfc_flag.sv
module tfc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_wr_i,
  input  logic ack_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_wr_i | ack_i;
    flag_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n) set_i |=> flag_q); // R2
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (clr_wr_i && !set_i) |=> !flag_q); // R4
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (ack_i && !set_i) |=> !flag_q); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (set_i && (clr_wr_i || ack_i)) |=> flag_q); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (flag_q && !clr_wr_i && !ack_i) |=> flag_q); // R4
endmodule

// File: rtl/tfc_psr.sv
module tfc_psr (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic wr_tsm_i,
  input  logic wr_psr_i,
  input  logic async_i,
  input  logic done_i,
  output logic tsm_o,
  output logic psr_o
);
  logic tsm_q, tsm_d;
  logic psr_q, psr_d;
  logic hw_release;

  always_comb begin
    // hardware may drop the reset bit only when the sync-mode hold is off
    hw_release = psr_q & ~tsm_q & (~async_i | done_i);
    tsm_d      = wr_i ? wr_tsm_i : tsm_q;
    if (wr_i && wr_psr_i) psr_d = 1'b1;
    else if (hw_release)  psr_d = 1'b0;
    else                  psr_d = psr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tsm_q <= 1'b0;
      psr_q <= 1'b0;
    end else begin
      tsm_q <= tsm_d;
      psr_q <= psr_d;
    end
  end

  assign tsm_o = tsm_q;
  assign psr_o = psr_q;

  AST_PSR_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n) (wr_i && wr_psr_i) |=> psr_q); // R8
  AST_PSR_SYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (psr_q && !tsm_q && !async_i && !(wr_i && wr_psr_i)) |=> !psr_q); // R9
  AST_PSR_ASYNC_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (psr_q && async_i && !done_i) |=> psr_q); // R10
  AST_PSR_TSM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (psr_q && tsm_q) |=> psr_q); // R11
  AST_PSR_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) (!psr_q && !(wr_i && wr_psr_i)) |=> !psr_q); // R8
endmodule

// File: rtl/tmr_flag_ctrl.sv
module tmr_flag_ctrl
  import tfc_pkg::*;
#(
  parameter int unsigned DW = TFC_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_sel,
  input  logic          reg_wr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cnt_ovf,
  input  logic          cnt_bottom,
  input  logic          cnt_match,
  input  logic          pwm_mode,
  input  logic          gie,
  input  logic          ovf_ie,
  input  logic          cmp_ie,
  input  logic          ack_ovf,
  input  logic          ack_cmp,
  input  logic          async_mode,
  input  logic          psr_done,
  output logic          irq_ovf,
  output logic          irq_cmp,
  output logic          psr_out
);
  localparam int unsigned NF = TFC_NFLAG;

  logic          rst_q;
  logic          wr_flags;
  logic          wr_ctrl;
  logic [NF-1:0] set_v;
  logic [NF-1:0] ack_v;
  logic [NF-1:0] ie_v;
  logic [NF-1:0] flag_q;
  logic [NF-1:0] irq_v;
  logic          tsm_q;
  logic          psr_q;
  logic          unused_wbits;

  assign unused_wbits = ^reg_wdata;

  tfc_rst_sync #(.STAGES(2)) u_rst (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_q (rst_q)
  );

  always_comb begin
    wr_flags       = reg_wr & (reg_sel == SEL_FLAGS);
    wr_ctrl        = reg_wr & (reg_sel == SEL_CTRL);
    set_v          = '0;
    set_v[OVF_BIT] = pwm_mode ? cnt_bottom : cnt_ovf;
    set_v[CMP_BIT] = cnt_match;
    ack_v          = '0;
    ack_v[OVF_BIT] = ack_ovf;
    ack_v[CMP_BIT] = ack_cmp;
    ie_v           = '0;
    ie_v[OVF_BIT]  = ovf_ie;
    ie_v[CMP_BIT]  = cmp_ie;
  end

  for (genvar g = 0; g < NF; g++) begin : g_flag
    tfc_flag u_flag (
      .clk      (clk),
      .rst_n    (rst_q),
      .set_i    (set_v[g]),
      .clr_wr_i (wr_flags & reg_wdata[g]),
      .ack_i    (ack_v[g]),
      .flag_o   (flag_q[g])
    );
    assign irq_v[g] = gie & ie_v[g] & flag_q[g];
  end

  tfc_psr u_psr (
    .clk      (clk),
    .rst_n    (rst_q),
    .wr_i     (wr_ctrl),
    .wr_tsm_i (reg_wdata[TSM_BIT]),
    .wr_psr_i (reg_wdata[PSR_BIT]),
    .async_i  (async_mode),
    .done_i   (psr_done),
    .tsm_o    (tsm_q),
    .psr_o    (psr_q)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel == SEL_CTRL) begin
      reg_rdata[TSM_BIT] = tsm_q;
      reg_rdata[PSR_BIT] = psr_q;
    end else begin
      reg_rdata[NF-1:0] = flag_q;
    end
  end

  assign irq_ovf = irq_v[OVF_BIT];
  assign irq_cmp = irq_v[CMP_BIT];
  assign psr_out = psr_q;

  AST_IRQ_GATED_BY_GIE: assert property (@(posedge clk) disable iff (!rst_q) !gie |-> (!irq_ovf && !irq_cmp)); // R7
  AST_IRQ_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_q) (ack_ovf && !set_v[OVF_BIT]) |=> !irq_ovf); // R5
  AST_PSR_PORT_MATCH: assert property (@(posedge clk) disable iff (!rst_q) (reg_sel == SEL_CTRL) |-> (reg_rdata[PSR_BIT] == psr_out)); // R8
endmodule

// File: tb/sim_tmr_flag_ctrl.sv
module sim_tmr_flag_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_sel, reg_wr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       cnt_ovf, cnt_bottom, cnt_match, pwm_mode;
  logic       gie, ovf_ie, cmp_ie, ack_ovf, ack_cmp;
  logic       async_mode, psr_done;
  logic       irq_ovf, irq_cmp, psr_out;

  always #5 clk = ~clk;

  tmr_flag_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_ovf(cnt_ovf),
    .cnt_bottom(cnt_bottom), .cnt_match(cnt_match), .pwm_mode(pwm_mode),
    .gie(gie), .ovf_ie(ovf_ie), .cmp_ie(cmp_ie), .ack_ovf(ack_ovf),
    .ack_cmp(ack_cmp), .async_mode(async_mode), .psr_done(psr_done),
    .irq_ovf(irq_ovf), .irq_cmp(irq_cmp), .psr_out(psr_out)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";
  bit    m_ovf, m_cmp, m_tsm, m_psr;

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // behavioural reference, stepped at each active edge
  task automatic model_step();
    bit set_o, set_c, clr_o, clr_c, old_tsm;
    set_o = pwm_mode ? cnt_bottom : cnt_ovf;
    set_c = cnt_match;
    clr_o = (reg_wr && !reg_sel && reg_wdata[0]) || ack_ovf;
    clr_c = (reg_wr && !reg_sel && reg_wdata[1]) || ack_cmp;
    if (set_o) m_ovf = 1; else if (clr_o) m_ovf = 0;
    if (set_c) m_cmp = 1; else if (clr_c) m_cmp = 0;
    old_tsm = m_tsm;
    if (reg_wr && reg_sel) m_tsm = reg_wdata[7];
    if (reg_wr && reg_sel && reg_wdata[1]) m_psr = 1;
    else if (m_psr && !old_tsm && (!async_mode || psr_done)) m_psr = 0;
  endtask

  task automatic compare_all();
    int exp_rd;
    exp_rd = reg_sel ? ((int'(m_tsm) << 7) | (int'(m_psr) << 1))
                     : ((int'(m_cmp) << 1) | int'(m_ovf));
    chk("reg_rdata", int'(reg_rdata), exp_rd);
    chk("irq_ovf", int'(irq_ovf), int'(gie & ovf_ie & m_ovf));
    chk("irq_cmp", int'(irq_cmp), int'(gie & cmp_ie & m_cmp));
    chk("psr_out", int'(psr_out), int'(m_psr));
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst_n) model_step();
    #1;
    compare_all();
  endtask

  task automatic idle();
    reg_sel = 0; reg_wr = 0; reg_wdata = 0;
    cnt_ovf = 0; cnt_bottom = 0; cnt_match = 0; pwm_mode = 0;
    gie = 0; ovf_ie = 0; cmp_ie = 0; ack_ovf = 0; ack_cmp = 0;
    async_mode = 0; psr_done = 0;
  endtask

  task automatic wr(input bit sel, input logic [7:0] d);
    reg_sel = sel; reg_wr = 1; reg_wdata = d;
    tick();
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [15:0] lfsr;
    idle();
    rst_n = 0;
    m_ovf = 0; m_cmp = 0; m_tsm = 0; m_psr = 0;
    cur_req = "R1";
    repeat (3) tick();
    reg_sel = 1; tick(); reg_sel = 0;
    rst_n = 1;
    repeat (4) tick();
    // R1: unused bits read 0 after writes of ones
    wr(1, 8'h7D); reg_sel = 1; tick();
    wr(0, 8'hFC); tick();

    cur_req = "R2";
    cnt_match = 1; tick(); cnt_match = 0; tick();
    cnt_ovf = 1; tick(); cnt_ovf = 0; tick();

    cur_req = "R4";
    wr(0, 8'h00); tick();
    wr(0, 8'h01); tick();
    wr(0, 8'h02); tick();

    cur_req = "R3";
    pwm_mode = 1;
    cnt_ovf = 1; tick(); cnt_ovf = 0; tick();
    cnt_bottom = 1; tick(); cnt_bottom = 0; tick();
    wr(0, 8'h03);
    pwm_mode = 0;
    cnt_bottom = 1; tick(); cnt_bottom = 0; tick();

    cur_req = "R5";
    cnt_ovf = 1; cnt_match = 1; tick(); cnt_ovf = 0; cnt_match = 0;
    ack_ovf = 1; tick(); ack_ovf = 0; tick();
    ack_cmp = 1; tick(); ack_cmp = 0; tick();

    cur_req = "R6";
    cnt_ovf = 1; cnt_match = 1; reg_sel = 0; reg_wr = 1; reg_wdata = 8'h03;
    tick(); cnt_ovf = 0; cnt_match = 0; reg_wr = 0; reg_wdata = 0; tick();
    cnt_ovf = 1; ack_ovf = 1; cnt_match = 1; ack_cmp = 1;
    tick(); cnt_ovf = 0; ack_ovf = 0; cnt_match = 0; ack_cmp = 0; tick();

    cur_req = "R7";
    for (int i = 0; i < 8; i++) begin
      gie = i[0]; ovf_ie = i[1]; cmp_ie = i[2];
      tick();
    end
    ack_cmp = 1; tick(); ack_cmp = 0;
    for (int i = 0; i < 8; i++) begin
      gie = i[0]; ovf_ie = i[1]; cmp_ie = i[2];
      tick();
    end
    gie = 0; ovf_ie = 0; cmp_ie = 0;

    cur_req = "R9";
    reg_sel = 1;
    wr(1, 8'h02); tick(); tick();

    cur_req = "R8";
    wr(1, 8'h80); reg_sel = 1; tick();
    wr(1, 8'h00); reg_sel = 1; tick();

    cur_req = "R10";
    async_mode = 1;
    wr(1, 8'h02); reg_sel = 1;
    repeat (4) tick();
    psr_done = 1; tick(); psr_done = 0; tick();
    // new write coinciding with done: write wins
    wr(1, 8'h02); psr_done = 1; reg_sel = 1; reg_wr = 1; reg_wdata = 8'h02;
    tick(); reg_wr = 0; reg_wdata = 0; tick(); psr_done = 0; tick();

    cur_req = "R11";
    wr(1, 8'h82); reg_sel = 1;
    psr_done = 1; repeat (3) tick();
    async_mode = 0; repeat (3) tick();
    psr_done = 0;

    cur_req = "R12";
    wr(1, 8'h00); reg_sel = 1; tick(); tick();
    wr(1, 8'h82); async_mode = 1; wr(1, 8'h00); reg_sel = 1;
    repeat (3) tick();
    psr_done = 1; tick(); psr_done = 0; tick();
    async_mode = 0;

    cur_req = "R6 mixed";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cnt_ovf = lfsr[0] & lfsr[5];
      cnt_bottom = lfsr[1] & lfsr[6];
      cnt_match = lfsr[2] & lfsr[7];
      pwm_mode = lfsr[3];
      gie = lfsr[4]; ovf_ie = lfsr[8]; cmp_ie = lfsr[9];
      ack_ovf = lfsr[10] & lfsr[11];
      ack_cmp = lfsr[12] & lfsr[11];
      async_mode = lfsr[13];
      psr_done = lfsr[14] & lfsr[2];
      reg_sel = lfsr[15];
      reg_wr = lfsr[5] & lfsr[9] & lfsr[1];
      reg_wdata = {lfsr[7] & lfsr[3], lfsr[12:6], lfsr[0]};
      tick();
    end
    idle();
    tick();
    summary();
  end
endmodule